// File: doc/BRIEF.md
# Power-On and Software Reset Sequencer

This block orders the reset of a processor-style device. An external active-low power-on input starts a full sequence. The input is first synchronised. The block then holds every reset output high and waits for the clock generator to report lock. After that it counts a fixed number of clocks and releases reset. Throughout this window it keeps sampling the clock-mode strap pins. At the release edge it freezes the last sample, which is then presented as the clock configuration for the rest of operation.

A software reset request from the CPU, taken only while the device runs normally, pulses the system reset for the same fixed count. It does not wait for lock again, does not touch the bus-arbiter reset and does not re-sample the straps. A slave-mode strap disables the software request. A bus-idle status shows when no reset is active. A clock-output force status goes high when the frozen strap value equals a chosen code.

Top module: `reset_sequencer`

## Requirements
- R1: While `por_n` is low, and until it has passed the synchroniser after going high, `hard_rst`, `soft_rst` and `arb_rst` are high and `bus_idle` is low.
- R2: After power-on release, all resets stay high for as long as `pll_locked` has not been sampled high, however long that takes (at least 500 to 2000 cycles).
- R3: `hard_rst`, `soft_rst` and `arb_rst` fall together exactly HOLD_CYCLES clocks after the first rising edge at which `pll_locked` is seen high, so they are high for HOLD_CYCLES cycles after that edge.
- R4: During the power-on window `mode_latched` takes the value of `mode_pins` at every rising edge, including the release edge. After release it is frozen, and a software reset does not change it.
- R5: When `sw_reset_req` is high at a rising edge while `bus_idle` is high and `slave_strap` is low, `soft_rst` goes high after that edge for exactly HOLD_CYCLES cycles. `hard_rst` and `arb_rst` stay low during this pulse, and `pll_locked` is not consulted.
- R6: A `sw_reset_req` that arrives while a software reset pulse is running neither restarts nor lengthens it.
- R7: While `slave_strap` is high, `sw_reset_req` has no effect and `soft_rst` stays low. The power-on sequence is the same for either strap value.
- R8: `bus_idle` is high exactly when both `hard_rst` and `soft_rst` are low.
- R9: `clkout_force` is high when `mode_latched` equals CLKOUT_CODE (default 2'b01), and low for every other value.
- R10: Dropping `pll_locked` after release does not re-assert any reset output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| pll_locked | input | 1 | Lock indication from the clock generator |
| sw_reset_req | input | 1 | Software reset command from the CPU |
| slave_strap | input | 1 | High disables the software reset command |
| mode_pins | input | MODE_W | Clock-mode strap pins |
| hard_rst | output | 1 | Power-on (hard) reset, active high |
| soft_rst | output | 1 | System (soft) reset, active high |
| arb_rst | output | 1 | Bus-arbiter reset, power-on only |
| mode_latched | output | MODE_W | Strap value, frozen at reset release |
| bus_idle | output | 1 | High when no reset is asserted |
| clkout_force | output | 1 | High when the frozen strap equals CLKOUT_CODE |

## Verification
The bench drives inputs on the falling edge and reads the outputs on the next falling edge, half a period after the rising edge that updates them. Every output is decoded from a registered state, so each result is due one rising edge after the stimulus that causes it. The release count starts at the edge that first sees lock, and the bench counts the falling edges at which reset is still high; that count must equal HOLD_CYCLES exactly. The strap value expected after release is the one the bench drove just before the final counted edge, and the same counting applies to the software pulse, including when a second request arrives in the middle of it.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

   typedef enum logic [2:0] {
      ST_POR_HOLD      = 3'd0,
      ST_WAIT_LOCK     = 3'd1,
      ST_COUNT_RELEASE = 3'd2,
      ST_RUN           = 3'd3,
      ST_SOFT_RESET    = 3'd4
   } rstseq_state_e;

   function automatic logic in_por_window(input rstseq_state_e st);
      return (st == ST_POR_HOLD) || (st == ST_WAIT_LOCK) || (st == ST_COUNT_RELEASE);
   endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic active
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge arst_n) begin
               if (!arst_n) chain[i] <= 1'b0;
               else         chain[i] <= 1'b1;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge arst_n) begin
               if (!arst_n) chain[i] <= 1'b0;
               else         chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign active = ~chain[STAGES-1];
endmodule

// File: rtl/rstseq_cnt.sv
module rstseq_cnt #(
   parameter int HOLD_CYCLES = 512,
   localparam int CW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1
) (
   input  logic clk,
   input  logic arst,
   input  logic load,
   input  logic en,
   output logic zero
);
   localparam logic [CW-1:0] START = CW'(HOLD_CYCLES - 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or posedge arst) begin
      if (arst)                  cnt <= START;
      else if (load)             cnt <= START;
      else if (en && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/rstseq_mode_latch.sv
module rstseq_mode_latch #(
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              sample,
   input  logic [MODE_W-1:0] pins,
   output logic [MODE_W-1:0] value
);
   generate
      for (genvar b = 0; b < MODE_W; b++) begin : g_bit
         always_ff @(posedge clk) begin
            if (sample) value[b] <= pins[b];
         end
      end
   endgenerate
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
   import rstseq_pkg::*;
#(
   parameter int              HOLD_CYCLES = 512,
   parameter int              MODE_W      = 2,
   parameter int              SYNC_STAGES = 2,
   parameter bit              CLKOUT_EN   = 1'b1,
   parameter logic [MODE_W-1:0] CLKOUT_CODE = MODE_W'(1)
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              pll_locked,
   input  logic              sw_reset_req,
   input  logic              slave_strap,
   input  logic [MODE_W-1:0] mode_pins,
   output logic              hard_rst,
   output logic              soft_rst,
   output logic              arb_rst,
   output logic [MODE_W-1:0] mode_latched,
   output logic              bus_idle,
   output logic              clkout_force
);
   generate
      if (HOLD_CYCLES < 2) begin : g_bad_hold
         initial $fatal(1, "HOLD_CYCLES must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         initial $fatal(1, "SYNC_STAGES must be at least 2");
      end
      if (MODE_W < 1) begin : g_bad_mode
         initial $fatal(1, "MODE_W must be at least 1");
      end
   endgenerate

   logic          por_hold;
   logic          cnt_zero;
   logic          cnt_load;
   logic          cnt_en;
   logic          sw_take;
   rstseq_state_e state, state_nx;

   rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (por_n),
      .active (por_hold)
   );

   assign sw_take = sw_reset_req & ~slave_strap;

   always_comb begin
      state_nx = state;
      cnt_load = 1'b0;
      unique case (state)
         ST_POR_HOLD:      state_nx = ST_WAIT_LOCK;
         ST_WAIT_LOCK:     if (pll_locked) begin
                              state_nx = ST_COUNT_RELEASE;
                              cnt_load = 1'b1;
                           end
         ST_COUNT_RELEASE: if (cnt_zero) state_nx = ST_RUN;
         ST_RUN:           if (sw_take) begin
                              state_nx = ST_SOFT_RESET;
                              cnt_load = 1'b1;
                           end
         ST_SOFT_RESET:    if (cnt_zero) state_nx = ST_RUN;
         default:          state_nx = ST_POR_HOLD;
      endcase
   end

   always_ff @(posedge clk or posedge por_hold) begin
      if (por_hold) state <= ST_POR_HOLD;
      else          state <= state_nx;
   end

   assign cnt_en = (state == ST_COUNT_RELEASE) || (state == ST_SOFT_RESET);

   rstseq_cnt #(.HOLD_CYCLES(HOLD_CYCLES)) u_cnt (
      .clk  (clk),
      .arst (por_hold),
      .load (cnt_load),
      .en   (cnt_en),
      .zero (cnt_zero)
   );

   rstseq_mode_latch #(.MODE_W(MODE_W)) u_mode (
      .clk    (clk),
      .sample (por_hold | in_por_window(state)),
      .pins   (mode_pins),
      .value  (mode_latched)
   );

   assign hard_rst = in_por_window(state);
   assign arb_rst  = in_por_window(state);
   assign soft_rst = in_por_window(state) || (state == ST_SOFT_RESET);
   assign bus_idle = (state == ST_RUN);

   generate
      if (CLKOUT_EN) begin : g_clkout
         assign clkout_force = (mode_latched == CLKOUT_CODE);
      end else begin : g_no_clkout
         assign clkout_force = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/reset_sequencer_checker.sv
module reset_sequencer_checker #(
   parameter int HOLD_CYCLES = 512,
   parameter int MODE_W      = 2
) (
   input logic              clk,
   input logic              por_active,
   input logic              pll_locked,
   input logic              sw_reset_req,
   input logic              slave_strap,
   input logic              hard_rst,
   input logic              soft_rst,
   input logic              arb_rst,
   input logic              bus_idle,
   input logic [MODE_W-1:0] mode_latched
);
   logic [31:0] soft_len;

   always_ff @(posedge clk or posedge por_active) begin
      if (por_active)                soft_len <= '0;
      else if (soft_rst && !hard_rst) soft_len <= soft_len + 1;
      else                           soft_len <= '0;
   end

   AST_HARD_WITH_SOFT: assert property (@(posedge clk) disable iff (por_active)
      hard_rst |-> (soft_rst && arb_rst)); // R1

   AST_IDLE_EXCL: assert property (@(posedge clk) disable iff (por_active)
      bus_idle |-> (!hard_rst && !soft_rst)); // R8

   AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (por_active)
      (!hard_rst && $past(!hard_rst)) |-> $stable(mode_latched)); // R4

   AST_SOFT_START: assert property (@(posedge clk) disable iff (por_active)
      (bus_idle && sw_reset_req && !slave_strap) |=> (soft_rst && !hard_rst && !arb_rst)); // R5

   AST_SOFT_LEN: assert property (@(posedge clk) disable iff (por_active)
      ($fell(soft_rst) && !$past(hard_rst)) |-> (soft_len == HOLD_CYCLES)); // R6

   AST_SLAVE_IGNORE: assert property (@(posedge clk) disable iff (por_active)
      (bus_idle && slave_strap) |=> !soft_rst); // R7

   AST_NO_REENTRY: assert property (@(posedge clk) disable iff (por_active)
      (bus_idle && !pll_locked) |=> !hard_rst); // R10
endmodule

bind reset_sequencer reset_sequencer_checker #(
   .HOLD_CYCLES (HOLD_CYCLES),
   .MODE_W      (MODE_W)
) u_chk (
   .clk          (clk),
   .por_active   (por_hold),
   .pll_locked   (pll_locked),
   .sw_reset_req (sw_reset_req),
   .slave_strap  (slave_strap),
   .hard_rst     (hard_rst),
   .soft_rst     (soft_rst),
   .arb_rst      (arb_rst),
   .bus_idle     (bus_idle),
   .mode_latched (mode_latched)
);

// File: tb/reset_sequencer_bench.sv
`timescale 1ns/1ps
module reset_sequencer_bench;
   localparam int N  = 512;
   localparam int MW = 2;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          pll_locked = 1'b0;
   logic          sw_reset_req = 1'b0;
   logic          slave_strap = 1'b0;
   logic [MW-1:0] mode_pins = '0;
   logic          hard_rst, soft_rst, arb_rst, bus_idle, clkout_force;
   logic [MW-1:0] mode_latched;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   always #5 clk = ~clk;

   reset_sequencer #(.HOLD_CYCLES(N), .MODE_W(MW)) u_reset_sequencer (
      .clk          (clk),
      .por_n        (por_n),
      .pll_locked   (pll_locked),
      .sw_reset_req (sw_reset_req),
      .slave_strap  (slave_strap),
      .mode_pins    (mode_pins),
      .hard_rst     (hard_rst),
      .soft_rst     (soft_rst),
      .arb_rst      (arb_rst),
      .mode_latched (mode_latched),
      .bus_idle     (bus_idle),
      .clkout_force (clkout_force)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_clkout(input logic [MW-1:0] m);
      return (m == 2'b01) ? 1 : 0;
   endfunction

   function automatic int exp_idle(input logic h, input logic s);
      return (!h && !s) ? 1 : 0;
   endfunction

   task automatic por_run(input bit slv, input bit want01);
      int d, cnt, arb_bad;
      logic [MW-1:0] prev, last;
      por_n = 1'b0; pll_locked = 1'b0; sw_reset_req = 1'b0; slave_strap = slv;
      mode_pins = MW'($urandom);
      repeat (4) @(negedge clk);
      chk("R1 hard", hard_rst, 1);
      chk("R1 soft", soft_rst, 1);
      chk("R1 arb", arb_rst, 1);
      chk("R1 idle", bus_idle, 0);
      chk("R4 sampled in reset", mode_latched, mode_pins);
      por_n = 1'b1;
      sw_reset_req = 1'b1;
      d = 500 + int'($urandom % 1501);
      prev = mode_pins;
      for (int i = 0; i < d; i++) begin
         @(negedge clk);
         prev = mode_pins;
         mode_pins = MW'($urandom);
      end
      sw_reset_req = 1'b0;
      chk("R2 hold before lock", hard_rst, 1);
      chk("R2 soft before lock", soft_rst, 1);
      chk("R4 tracking", mode_latched, prev);
      pll_locked = 1'b1;
      cnt = 0; arb_bad = 0; last = mode_pins;
      while (cnt < 4 * N) begin
         @(negedge clk);
         if (!hard_rst) break;
         cnt++;
         if (!arb_rst || !soft_rst) arb_bad++;
         last = (want01 && cnt == N) ? 2'b01 : MW'($urandom);
         if (want01 && cnt != N && last == 2'b01) last = 2'b10;
         mode_pins = last;
      end
      chk("R3 release length", cnt, N);
      chk("R3 arb/soft during count", arb_bad, 0);
      chk("R3 soft released", soft_rst, 0);
      chk("R3 arb released", arb_rst, 0);
      chk("R8 idle after release", bus_idle, exp_idle(hard_rst, soft_rst));
      chk("R4 frozen at release edge", mode_latched, last);
      chk("R9 clkout", clkout_force, exp_clkout(last));
      for (int i = 0; i < 10; i++) begin
         mode_pins = ~last;
         @(negedge clk);
      end
      chk("R4 frozen after release", mode_latched, last);
   endtask

   task automatic soft_run(input bit extra);
      int cnt, bad;
      logic [MW-1:0] keep;
      keep = mode_latched;
      pll_locked = 1'b0;
      sw_reset_req = 1'b1;
      @(negedge clk);
      sw_reset_req = 1'b0;
      cnt = 0; bad = 0;
      while (soft_rst && cnt < 4 * N) begin
         cnt++;
         if (hard_rst || arb_rst || bus_idle) bad++;
         mode_pins = MW'($urandom);
         sw_reset_req = (extra && (cnt == 100 || cnt == N - 1)) ? 1'b1 : 1'b0;
         @(negedge clk);
      end
      sw_reset_req = 1'b0;
      if (extra) chk("R6 no restart length", cnt, N);
      else       chk("R5 soft length", cnt, N);
      chk("R5 no hard/arb during soft", bad, 0);
      chk("R4 not resampled by soft", mode_latched, keep);
      chk("R8 idle after soft", bus_idle, 1);
      pll_locked = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic slave_try();
      int seen;
      slave_strap = 1'b1;
      sw_reset_req = 1'b1;
      seen = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (soft_rst) seen++;
      end
      sw_reset_req = 1'b0;
      chk("R7 slave ignores request", seen, 0);
      chk("R7 idle kept", bus_idle, 1);
      slave_strap = 1'b0;
      @(negedge clk);
   endtask

   task automatic lock_loss();
      int seen;
      pll_locked = 1'b0;
      seen = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (hard_rst || soft_rst || arb_rst) seen++;
      end
      chk("R10 no reset on lock loss", seen, 0);
      pll_locked = 1'b1;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      por_run(1'b0, 1'b0);
      lock_loss();
      soft_run(1'b0);
      soft_run(1'b1);
      slave_try();
      por_run(1'b1, 1'b1);
      slave_try();
      soft_run(1'b1);
      por_run(1'b0, 1'b0);
      for (int k = 0; k < 3; k++) soft_run(($urandom % 2) == 1);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule